// File: doc/BRIEF.md
# In-Place FFT Stage Sequencer

This controller drives a radix-2 decimation-in-time FFT datapath that works in place on one of two input banks and sends its final results to a separate output buffer. One butterfly, which is one pair of samples, is issued per clock. A stage issues N/2 butterflies and then waits a fixed pipeline latency LAT, so every stage lasts N/2 + LAT cycles. A transform has log2N stages. For every butterfly the sequencer produces the two read addresses and the bank select. The two write addresses are the same pair, delayed by LAT cycles. In the last stage the writes are steered to the output buffer instead of back to the in-place bank.

The host loads the next frame through a valid/ready stream into whichever input bank is idle. The sequencer supplies the load address. Back-pressure applies once that bank holds N samples: `ld_ready` stays low and any `ld_valid` is ignored until the next transform starts. The next transform starts when the idle bank is full and no transform is running. At that point the bank roles swap and the fill count clears.

`out_rd_ok` tells the host when the output buffer may be read. It rises with the done pulse. It stays high until the following transform reaches its last stage, which is the stage that overwrites the buffer.

Top module: `fft_stage_seq`

## Requirements
- R1: `ld_ready` is high while the idle bank holds fewer than N samples. Accepted samples get `ld_addr` values 0,1,…,N−1 in order, and `ld_bank` is the complement of `rd_bank`. A `ld_valid` seen while `ld_ready` is low is not counted.
- R2: A transform starts, with `busy` rising, only in the cycle after the idle bank holds N samples while no transform is running. At that start `rd_bank` takes the freshly loaded bank and the fill count restarts at 0.
- R3: Each stage lasts N/2+LAT cycles. `rd_en` is high for exactly its first N/2 cycles. `stage` counts 0 to log2N−1, and `busy` stays high for (N/2+LAT)·log2N cycles.
- R4: In stage s (counted from 0), butterfly j reads `rd_addr_a` = (j div 2^s)·2^(s+1) + (j mod 2^s) and `rd_addr_b` = `rd_addr_a` + 2^s.
- R5: `wr_en`, `wr_addr_a` and `wr_addr_b` repeat `rd_en` and the read addresses exactly LAT cycles later. All writes of a stage fall inside that stage.
- R6: `wr_to_out` is high on writes of the last stage only. `wr_bank` equals `rd_bank` during a transform.
- R7: `done` is a single-cycle pulse in the cycle after the last write of the last stage. `busy` is low in that cycle.
- R8: `out_rd_ok` is low until the first transform completes. It rises with `done` and stays high, including while idle, until the next transform enters its last stage.
- R9: Within every stage, each of the N in-place addresses is written exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Host offers an input sample |
| ld_ready | output | 1 | Idle bank can accept a sample |
| ld_addr | output | log2N | Write address in the idle bank |
| ld_bank | output | 1 | Bank being loaded by the host |
| rd_en | output | 1 | Butterfly read issue |
| rd_addr_a | output | log2N | Upper-leg read address |
| rd_addr_b | output | log2N | Lower-leg read address |
| rd_bank | output | 1 | Active in-place bank |
| wr_en | output | 1 | Butterfly result write |
| wr_addr_a | output | log2N | Upper-leg write address |
| wr_addr_b | output | log2N | Lower-leg write address |
| wr_bank | output | 1 | Bank receiving in-place writes |
| wr_to_out | output | 1 | Write goes to the output buffer |
| stage | output | clog2(log2N) | Current stage index |
| busy | output | 1 | Transform in progress |
| done | output | 1 | Transform complete pulse |
| out_rd_ok | output | 1 | Output buffer may be read |

## Verification
The hardest case to reach is a transform that starts back-to-back with the previous one. That needs a frame fully loaded during the previous transform. The read window must then close at the second transform's last stage without ever having been idle in between. The bench produces this by streaming the next frame into the idle bank during the first sweep of the first transform. It then follows every cycle of the second transform. A third transform is started only after an idle gap, which shows the window staying open while idle. A sample offered into a full bank just before a start shows that the ignored beat never moves the load address.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;
  typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} seq_state_t;
endpackage

// File: rtl/fft_load_ctl.sv
module fft_load_ctl #(
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_valid,
  input  logic                 restart,
  output logic                 ld_ready,
  output logic [$clog2(N)-1:0] ld_addr,
  output logic                 full
);
  localparam int AW = $clog2(N);
  logic [AW:0] fill_q;

  assign full     = (fill_q == (AW+1)'(N));
  assign ld_ready = !full;
  assign ld_addr  = fill_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)                    fill_q <= '0;
    else if (restart)              fill_q <= '0;
    else if (ld_valid && ld_ready) fill_q <= fill_q + 1'b1;
  end
endmodule

// File: rtl/fft_addr_gen.sv
module fft_addr_gen #(
  parameter int AW = 4,
  parameter int SW = 2
) (
  input  logic [SW-1:0] stage,
  input  logic [AW-1:0] idx,
  output logic [AW-1:0] addr_a,
  output logic [AW-1:0] addr_b
);
  logic [AW-1:0] span, low_mask;

  always_comb begin
    span     = AW'(1) << stage;
    low_mask = span - 1'b1;
    addr_a   = ((idx & ~low_mask) << 1) | (idx & low_mask);
    addr_b   = addr_a | span;
  end
endmodule

// File: rtl/fft_wr_pipe.sv
module fft_wr_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] tap [DEPTH+1];
  assign tap[0] = din;

  for (genvar k = 0; k < DEPTH; k++) begin : g_tap
    always_ff @(posedge clk) begin
      if (!rst_n) tap[k+1] <= '0;
      else        tap[k+1] <= tap[k];
    end
  end

  assign dout = tap[DEPTH];
endmodule

// File: rtl/fft_stage_seq.sv
module fft_stage_seq
  import fft_seq_pkg::*;
#(
  parameter int N   = 16,
  parameter int LAT = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ld_valid,
  output logic                         ld_ready,
  output logic [$clog2(N)-1:0]         ld_addr,
  output logic                         ld_bank,
  output logic                         rd_en,
  output logic [$clog2(N)-1:0]         rd_addr_a,
  output logic [$clog2(N)-1:0]         rd_addr_b,
  output logic                         rd_bank,
  output logic                         wr_en,
  output logic [$clog2(N)-1:0]         wr_addr_a,
  output logic [$clog2(N)-1:0]         wr_addr_b,
  output logic                         wr_bank,
  output logic                         wr_to_out,
  output logic [$clog2($clog2(N))-1:0] stage,
  output logic                         busy,
  output logic                         done,
  output logic                         out_rd_ok
);
  localparam int STAGES = $clog2(N);
  localparam int AW     = STAGES;
  localparam int SW     = $clog2(STAGES);
  localparam int BFLY   = N / 2;
  localparam int SLEN   = BFLY + LAT;
  localparam int CW     = $clog2(SLEN + 1);
  localparam int PW     = 2 * AW + 2;

  seq_state_t    state_q;
  logic          act_bank_q;
  logic [SW-1:0] stage_q;
  logic [CW-1:0] cyc_q;
  logic          done_q, ok_q;
  logic          frame_full, start, stage_end, last_stage;
  logic [AW-1:0] ra, rb;
  logic [PW-1:0] pipe_in, pipe_out;

  fft_load_ctl #(.N(N)) u_load (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .restart(start),
    .ld_ready(ld_ready), .ld_addr(ld_addr), .full(frame_full)
  );

  assign start      = (state_q == S_IDLE) && frame_full;
  assign last_stage = (stage_q == SW'(STAGES - 1));
  assign stage_end  = (state_q == S_RUN) && (cyc_q == CW'(SLEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      act_bank_q <= 1'b1;
      stage_q    <= '0;
      cyc_q      <= '0;
      done_q     <= 1'b0;
      ok_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        state_q    <= S_RUN;
        act_bank_q <= ~act_bank_q;
        stage_q    <= '0;
        cyc_q      <= '0;
      end else if (state_q == S_RUN) begin
        if (stage_end) begin
          cyc_q <= '0;
          if (last_stage) begin
            state_q <= S_IDLE;
            stage_q <= '0;
            done_q  <= 1'b1;
            ok_q    <= 1'b1;
          end else begin
            stage_q <= stage_q + 1'b1;
            if (stage_q == SW'(STAGES - 2)) ok_q <= 1'b0;
          end
        end else begin
          cyc_q <= cyc_q + 1'b1;
        end
      end
    end
  end

  assign rd_en = (state_q == S_RUN) && (cyc_q < CW'(BFLY));

  fft_addr_gen #(.AW(AW), .SW(SW)) u_addr (
    .stage(stage_q), .idx(AW'(cyc_q)), .addr_a(ra), .addr_b(rb)
  );

  assign pipe_in = {rd_en, rd_en && last_stage, ra, rb};

  fft_wr_pipe #(.W(PW), .DEPTH(LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .din(pipe_in), .dout(pipe_out)
  );

  assign rd_addr_a = ra;
  assign rd_addr_b = rb;
  assign rd_bank   = act_bank_q;
  assign ld_bank   = ~act_bank_q;
  assign wr_en     = pipe_out[PW-1];
  assign wr_to_out = pipe_out[PW-2];
  assign wr_addr_a = pipe_out[2*AW-1:AW];
  assign wr_addr_b = pipe_out[AW-1:0];
  assign wr_bank   = act_bank_q;
  assign stage     = stage_q;
  assign busy      = (state_q == S_RUN);
  assign done      = done_q;
  assign out_rd_ok = ok_q;
endmodule

// File: rtl/fft_stage_seq_chk.sv
module fft_stage_seq_chk #(
  parameter int N   = 16,
  parameter int LAT = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         rd_en,
  input logic [$clog2(N)-1:0]         rd_addr_a,
  input logic [$clog2(N)-1:0]         rd_addr_b,
  input logic                         wr_en,
  input logic                         wr_to_out,
  input logic [$clog2($clog2(N))-1:0] stage,
  input logic                         busy,
  input logic                         done,
  input logic                         out_rd_ok
);
  localparam int AW     = $clog2(N);
  localparam int STAGES = AW;
  localparam int SW     = $clog2(STAGES);

  p_rden_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);

  p_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ((rd_addr_a ^ rd_addr_b) == (AW'(1) << stage)) && rd_addr_a < rd_addr_b);

  p_out_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_to_out |-> (wr_en && stage == SW'(STAGES - 1)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && out_rd_ok));

  p_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stage == SW'(STAGES - 1)) |-> !out_rd_ok);
endmodule

bind fft_stage_seq fft_stage_seq_chk #(.N(N), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr_a(rd_addr_a),
  .rd_addr_b(rd_addr_b), .wr_en(wr_en), .wr_to_out(wr_to_out),
  .stage(stage), .busy(busy), .done(done), .out_rd_ok(out_rd_ok)
);

// File: tb/fft_stage_seq_bench.sv
`timescale 1ns/1ps
module fft_stage_seq_bench;
  localparam int N      = 8;
  localparam int LAT    = 2;
  localparam int STAGES = 3;
  localparam int BFLY   = N / 2;
  localparam int SLEN   = BFLY + LAT;
  localparam int TOTAL  = SLEN * STAGES;

  logic clk = 1'b0, rst_n = 1'b0, ld_valid = 1'b0;
  logic ld_ready, ld_bank, rd_en, rd_bank, wr_en, wr_bank, wr_to_out;
  logic busy, done, out_rd_ok;
  logic [2:0] ld_addr, rd_addr_a, rd_addr_b, wr_addr_a, wr_addr_b;
  logic [1:0] stage;

  int checks = 0, errors = 0;
  bit finished = 0;
  int wcnt [N];

  always #2 clk = ~clk;

  fft_stage_seq #(.N(N), .LAT(LAT)) u_fft_stage_seq (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_bank(ld_bank), .rd_en(rd_en),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .rd_bank(rd_bank),
    .wr_en(wr_en), .wr_addr_a(wr_addr_a), .wr_addr_b(wr_addr_b),
    .wr_bank(wr_bank), .wr_to_out(wr_to_out), .stage(stage), .busy(busy),
    .done(done), .out_rd_ok(out_rd_ok)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int addr_a_of(input int s, input int j);
    int half = 1 << s;
    return (j / half) * 2 * half + (j % half);
  endfunction

  // Called at the first negedge with busy high; returns at the done cycle.
  task automatic run_frame(input logic bank, input bit load_next, input bit prior_ok);
    for (int k = 0; k < N; k++) wcnt[k] = 0;
    for (int t = 0; t < TOTAL; t++) begin
      int s = t / SLEN;
      int c = t % SLEN;
      bit exp_rd = (c < BFLY);
      bit exp_wr = (c >= LAT);
      bit exp_ok = prior_ok && (s < STAGES - 1);
      chk(busy == 1'b1, "R3 busy", busy, 1);
      chk(int'(stage) == s, "R3 stage", stage, s);
      chk(rd_en == exp_rd, "R3 rd_en", rd_en, exp_rd);
      chk(rd_bank == bank, "R2 rd_bank", rd_bank, bank);
      chk(wr_bank == bank, "R6 wr_bank", wr_bank, bank);
      chk(out_rd_ok == exp_ok, "R8 out_rd_ok", out_rd_ok, exp_ok);
      chk(done == 1'b0, "R7 no done mid-frame", done, 0);
      if (exp_rd) begin
        int ea = addr_a_of(s, c);
        chk(int'(rd_addr_a) == ea, "R4 rd_addr_a", rd_addr_a, ea);
        chk(int'(rd_addr_b) == ea + (1 << s), "R4 rd_addr_b", rd_addr_b, ea + (1 << s));
      end
      chk(wr_en == exp_wr, "R5 wr_en", wr_en, exp_wr);
      if (exp_wr) begin
        int ea = addr_a_of(s, c - LAT);
        bit eo = (s == STAGES - 1);
        chk(int'(wr_addr_a) == ea, "R5 wr_addr_a", wr_addr_a, ea);
        chk(int'(wr_addr_b) == ea + (1 << s), "R5 wr_addr_b", wr_addr_b, ea + (1 << s));
        chk(wr_to_out == eo, "R6 wr_to_out", wr_to_out, eo);
        wcnt[wr_addr_a]++;
        wcnt[wr_addr_b]++;
      end else begin
        chk(wr_to_out == 1'b0, "R6 wr_to_out idle", wr_to_out, 0);
      end
      if (c == SLEN - 1) begin
        for (int k = 0; k < N; k++) begin
          chk(wcnt[k] == 1, "R9 one write per address per stage", wcnt[k], 1);
          wcnt[k] = 0;
        end
      end
      if (load_next && t < N) begin
        chk(int'(ld_addr) == t, "R1 ld_addr", ld_addr, t);
        chk(ld_bank == ~bank, "R1 ld_bank", ld_bank, ~bank);
        chk(ld_ready == 1'b1, "R1 ld_ready", ld_ready, 1);
        ld_valid = 1'b1;
      end else begin
        ld_valid = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
    end
    ld_valid = 1'b0;
    chk(done == 1'b1, "R7 done pulse", done, 1);
    chk(busy == 1'b0, "R7 busy low at done", busy, 0);
    chk(out_rd_ok == 1'b1, "R8 window opens with done", out_rd_ok, 1);
  endtask

  initial begin
    #(4 * 5000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(busy == 0 && done == 0, "R2 reset idle", busy, 0);
    chk(out_rd_ok == 0, "R8 reset window closed", out_rd_ok, 0);
    chk(ld_ready == 1 && ld_bank == 0, "R1 reset ready bank0", ld_bank, 0);

    // Frame 1 with gaps between samples.
    for (int k = 0; k < N; k++) begin
      ld_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(int'(ld_addr) == k, "R1 gapped ld_addr", ld_addr, k);
      chk(busy == 0, "R2 no start before full", busy, 0);
      ld_valid = 1'b1;
      @(posedge clk); @(negedge clk);
    end
    // Bank full: offered beat must be ignored.
    chk(ld_ready == 1'b0, "R1 ready low when full", ld_ready, 0);
    chk(busy == 1'b0, "R2 start one cycle after full", busy, 0);
    @(posedge clk); @(negedge clk);
    ld_valid = 1'b0;
    chk(busy == 1'b1, "R2 start", busy, 1);
    chk(int'(ld_addr) == 0, "R1 ignored beat not counted", ld_addr, 0);
    run_frame(1'b0, 1'b1, 1'b0);

    // Frame 2 back to back.
    @(posedge clk); @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);
    chk(busy == 1'b1, "R2 back-to-back start", busy, 1);
    run_frame(1'b1, 1'b0, 1'b1);

    // Idle gap: window stays open.
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); @(negedge clk);
      chk(busy == 0 && done == 0, "R2 idle without frame", busy, 0);
      chk(out_rd_ok == 1, "R8 window open while idle", out_rd_ok, 1);
      chk(ld_ready == 1 && ld_bank == 0, "R1 ready for bank0", ld_bank, 0);
    end

    // Frame 3 loaded back to back.
    for (int k = 0; k < N; k++) begin
      chk(int'(ld_addr) == k, "R1 burst ld_addr", ld_addr, k);
      ld_valid = 1'b1;
      @(posedge clk); @(negedge clk);
    end
    ld_valid = 1'b0;
    chk(busy == 0 && ld_ready == 0, "R2 full then start", busy, 0);
    @(posedge clk); @(negedge clk);
    run_frame(1'b0, 1'b0, 1'b1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule